// File: doc/BRIEF.md
# Range-Matched Translation and Permission Checker

This block is a small, fully associative translation buffer that sits between an address generator and the memory system. It accepts one request per cycle: a virtual address, an access kind (load, store or instruction fetch) and the current privilege level. A cycle later it returns a translated physical address, the set of access rights the matching entry grants, and an encoded fault. An entry is selected when the address falls inside an inclusive begin/end window. The entry supplies a page-aligned physical base, an access-type code, two privilege bounds and three per-page flags: dirty, break and trap.

Entries are loaded through a simple indexed write port. Refill policy and page-table walking live outside the block. A translation-off input turns the block into a straight pass-through. An interruption-collection enable decides whether a faulting address is latched into a pair of interruption registers. The offset register takes the lower half of the address and the space register takes the upper half.

Top module: `tlbchk_top`

## Requirements
- R1: An entry matches only if its valid bit is set and `begin <= va <= end` (unsigned, both bounds inclusive). When several entries match, the one with the lowest index is used.
- R2: When `physMode` was high with the request, the response carries `rspPa == va`, `rspProt == 3'b111` and `rspFault == 0`, whatever the entries hold.
- R3: When no entry matches, `rspFault` is 1 for a fetch (`reqKind == 2`) and 2 for any other kind, and both `rspPa` and `rspProt` are zero. `reqKind` 0 is a load, 1 is a store, and 3 behaves as a load.
- R4: On a match, `rspPa` equals the entry's physical base plus the low 12 bits of the virtual address.
- R5: Let `priv` be the current privilege. Read is permitted when `priv <= pl1`. Write is permitted when `priv <= pl2`. Execute is permitted when `pl2 <= priv <= pl1`. In `rspProt`, bit 0 is read, bit 1 is write and bit 2 is execute.
- R6: The access-type code limits the granted set as follows. 0 gives read only. 1 gives read and write. 2 gives read and execute. 3 gives all three. Codes 4 to 7 give execute only.
- R7: If the granted set lacks the requested right (execute for a fetch, write for a store, read otherwise), `rspFault` is 3 for a fetch and 4 otherwise. `rspProt` is then the granted set, and the flag checks of R8 are not applied.
- R8: A clear dirty flag removes write from `rspProt` and gives fault 5 on a store. A set break flag removes write and gives fault 6 on a store. A set trap flag leaves only execute in `rspProt` and gives fault 7 on any access that is not a fetch.
- R9: When more than one flag fault applies, fault 7 wins over fault 6, and fault 6 wins over fault 5.
- R10: When a response has a nonzero fault and `collectEn` was high with its request, the next clock edge loads `offsetReg` with `va[15:0]` and `spaceReg` with `va[31:16]`. Otherwise both registers hold their values.
- R11: A request presented at a clock edge produces its response, with `rspValid` high, in the following cycle. An entry write presented at the same edge is already visible to that response. While `rspValid` is low, `rspPa`, `rspProt` and `rspFault` are zero.
- R12: After reset every entry is invalid, `rspValid` is low and both interruption registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 3 | Entry index to write |
| wrValid | input | 1 | Valid bit for the written entry |
| wrVaBegin | input | 32 | Lowest virtual address covered (inclusive) |
| wrVaEnd | input | 32 | Highest virtual address covered (inclusive) |
| wrPaBase | input | 32 | Physical base of the entry |
| wrAccType | input | 3 | Access-type code |
| wrPl1 | input | 2 | Upper privilege bound (read/execute) |
| wrPl2 | input | 2 | Lower privilege bound (write/execute) |
| wrDirty | input | 1 | Dirty flag |
| wrBreak | input | 1 | Break flag |
| wrTrap | input | 1 | Trap (page-reference) flag |
| reqValid | input | 1 | Lookup request strobe |
| reqVa | input | 32 | Virtual address to translate |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| reqPriv | input | 2 | Current privilege level |
| physMode | input | 1 | Translation off for this request |
| collectEn | input | 1 | Enable capture of a faulting address |
| rspValid | output | 1 | Response present this cycle |
| rspPa | output | 32 | Physical address |
| rspProt | output | 3 | Granted rights {exec, write, read} |
| rspFault | output | 3 | Fault code, 0 for none |
| offsetReg | output | 16 | Captured lower half of a faulting address |
| spaceReg | output | 16 | Captured upper half of a faulting address |

## Verification
Two functions can act in the same cycle: an entry write and a lookup request presented at the same edge. A clean lookup can also coincide with a rewrite of the very entry it needs. The bench provokes both cases, once in directed form on an empty slot and at random throughout the mixed run. Its reference model applies the write before it computes the expected result, so a response that still reflects the old entry contents is reported as a mismatch in address, rights or fault code.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_IMISS = 3'd1,
    FLT_DMISS = 3'd2,
    FLT_IPROT = 3'd3,
    FLT_DPROT = 3'd4,
    FLT_DIRTY = 3'd5,
    FLT_BREAK = 3'd6,
    FLT_PREF  = 3'd7
  } faultCode_t;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [2:0] PERM_R = 3'b001;
  localparam logic [2:0] PERM_W = 3'b010;
  localparam logic [2:0] PERM_X = 3'b100;

  typedef struct packed {
    logic latchReq;
    logic entryWr;
    logic lookupEn;
    logic bypass;
    logic capture;
  } tlbStrobe_t;

endpackage

// File: rtl/tlbchk_ctrl.sv
module tlbchk_ctrl
  import tlbchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       physMode,
  input  logic       collectEn,
  input  logic       wrEn,
  input  logic       faultAny,
  output tlbStrobe_t strb
);

  logic vldQ, bypQ, colQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ <= 1'b0;
      bypQ <= 1'b0;
      colQ <= 1'b0;
    end else begin
      vldQ <= reqValid;
      if (reqValid) begin
        bypQ <= physMode;
        colQ <= collectEn;
      end
    end
  end

  always_comb begin
    strb.latchReq = reqValid;
    strb.entryWr  = wrEn;
    strb.lookupEn = vldQ;
    strb.bypass   = bypQ;
    strb.capture  = vldQ & colQ & faultAny;
  end

  // R11: a response only follows a request one cycle earlier
  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.lookupEn |-> $past(reqValid));

  // R2: a bypassed lookup never raises a capture
  p_bypass_no_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lookupEn && strb.bypass) |-> !strb.capture);

endmodule

// File: rtl/tlbchk_dp.sv
module tlbchk_dp
  import tlbchk_pkg::*;
#(
  parameter int N_ENT     = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PL_W      = 2,
  parameter int AT_W      = 3,
  localparam int IDX_W    = $clog2(N_ENT),
  localparam int HALF_W   = VA_W / 2,
  localparam int UP_W     = VA_W - HALF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic [VA_W-1:0]   wrVaBegin,
  input  logic [VA_W-1:0]   wrVaEnd,
  input  logic [PA_W-1:0]   wrPaBase,
  input  logic [AT_W-1:0]   wrAccType,
  input  logic [PL_W-1:0]   wrPl1,
  input  logic [PL_W-1:0]   wrPl2,
  input  logic              wrDirty,
  input  logic              wrBreak,
  input  logic              wrTrap,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [1:0]        reqKind,
  input  logic [PL_W-1:0]   reqPriv,
  output logic [PA_W-1:0]   rspPa,
  output logic [2:0]        rspProt,
  output logic [2:0]        rspFault,
  output logic              faultAny,
  output logic [HALF_W-1:0] offsetReg,
  output logic [UP_W-1:0]   spaceReg
);

  logic [N_ENT-1:0] entValid;
  logic [VA_W-1:0]  vaBeg   [N_ENT];
  logic [VA_W-1:0]  vaEnd   [N_ENT];
  logic [PA_W-1:0]  paBase  [N_ENT];
  logic [AT_W-1:0]  accType [N_ENT];
  logic [PL_W-1:0]  plHi    [N_ENT];
  logic [PL_W-1:0]  plLo    [N_ENT];
  logic [N_ENT-1:0] dirtyF, breakF, trapF;

  logic [VA_W-1:0] qVa;
  logic [1:0]      qKind;
  logic [PL_W-1:0] qPriv;

  // entry storage: only the valid bits need a reset value
  always_ff @(posedge clk) begin
    if (!rstN) entValid <= '0;
    else if (strb.entryWr) entValid[wrIdx] <= wrValid;
  end

  always_ff @(posedge clk) begin
    if (strb.entryWr) begin
      vaBeg[wrIdx]   <= wrVaBegin;
      vaEnd[wrIdx]   <= wrVaEnd;
      paBase[wrIdx]  <= wrPaBase;
      accType[wrIdx] <= wrAccType;
      plHi[wrIdx]    <= wrPl1;
      plLo[wrIdx]    <= wrPl2;
      dirtyF[wrIdx]  <= wrDirty;
      breakF[wrIdx]  <= wrBreak;
      trapF[wrIdx]   <= wrTrap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qVa   <= '0;
      qKind <= KIND_LOAD;
      qPriv <= '0;
    end else if (strb.latchReq) begin
      qVa   <= reqVa;
      qKind <= reqKind;
      qPriv <= reqPriv;
    end
  end

  // range match per entry
  logic [N_ENT-1:0] hitVec;
  for (genvar g = 0; g < N_ENT; g++) begin : g_match
    assign hitVec[g] = entValid[g] && (vaBeg[g] <= qVa) && (qVa <= vaEnd[g]);
  end

  // lowest index wins
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (hitVec[i]) selIdx = IDX_W'(i);
  end

  logic isFetch, isStore;
  assign isFetch = (qKind == KIND_FETCH);
  assign isStore = (qKind == KIND_STORE);

  logic       canR, canW, canX;
  logic [2:0] grant, need;
  always_comb begin
    canR = (qPriv <= plHi[selIdx]);
    canW = (qPriv <= plLo[selIdx]);
    canX = (plLo[selIdx] <= qPriv) && (qPriv <= plHi[selIdx]);
    case (accType[selIdx])
      AT_W'(0): grant = {1'b0, 1'b0, canR};
      AT_W'(1): grant = {1'b0, canW, canR};
      AT_W'(2): grant = {canX, 1'b0, canR};
      AT_W'(3): grant = {canX, canW, canR};
      default:  grant = {canX, 1'b0, 1'b0};
    endcase
    need = isFetch ? PERM_X : (isStore ? PERM_W : PERM_R);
  end

  faultCode_t fault;
  logic [2:0] prot;
  logic [PA_W-1:0] pa;
  always_comb begin
    fault = FLT_NONE;
    prot  = '0;
    pa    = '0;
    if (strb.lookupEn) begin
      if (strb.bypass) begin
        pa   = PA_W'(qVa);
        prot = PERM_R | PERM_W | PERM_X;
      end else if (hitVec == '0) begin
        fault = isFetch ? FLT_IMISS : FLT_DMISS;
      end else begin
        pa   = paBase[selIdx] + {{(PA_W-PAGE_BITS){1'b0}}, qVa[PAGE_BITS-1:0]};
        prot = grant;
        if ((grant & need) == '0) begin
          fault = isFetch ? FLT_IPROT : FLT_DPROT;
        end else begin
          if (trapF[selIdx])                          prot = grant & PERM_X;
          else if (breakF[selIdx] || !dirtyF[selIdx]) prot = grant & ~PERM_W;
          if (trapF[selIdx] && !isFetch)              fault = FLT_PREF;
          else if (breakF[selIdx] && isStore)         fault = FLT_BREAK;
          else if (!dirtyF[selIdx] && isStore)        fault = FLT_DIRTY;
        end
      end
    end
  end

  assign rspPa    = pa;
  assign rspProt  = prot;
  assign rspFault = fault;
  assign faultAny = (fault != FLT_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetReg <= '0;
      spaceReg  <= '0;
    end else if (strb.capture) begin
      offsetReg <= qVa[HALF_W-1:0];
      spaceReg  <= qVa[VA_W-1:HALF_W];
    end
  end

  // R3: a miss carries no address and no rights
  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault == FLT_IMISS || rspFault == FLT_DMISS) |-> (rspPa == '0 && rspProt == '0));

  // R7: an instruction protection fault only answers a fetch
  p_iprot_fetch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault == FLT_IPROT) |-> (qKind == KIND_FETCH));

  // R8: page-reference fault leaves execute only
  p_pref_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault == FLT_PREF) |-> (rspProt[1:0] == 2'b00));

  // R8: dirty and break faults never return write
  p_wflag_nowrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault == FLT_DIRTY || rspFault == FLT_BREAK) |-> !rspProt[1]);

  // R10: capture loads the faulting address, otherwise registers hold
  p_capture_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (offsetReg == $past(qVa[HALF_W-1:0]) && spaceReg == $past(qVa[VA_W-1:HALF_W])));
  p_capture_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> ($stable(offsetReg) && $stable(spaceReg)));

  // R11: idle cycles drive zeros
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lookupEn |-> (rspFault == FLT_NONE && rspProt == '0 && rspPa == '0));

endmodule

// File: rtl/tlbchk_top.sv
module tlbchk_top
  import tlbchk_pkg::*;
#(
  parameter int N_ENT     = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PL_W      = 2,
  parameter int AT_W      = 3,
  localparam int IDX_W    = $clog2(N_ENT),
  localparam int HALF_W   = VA_W / 2,
  localparam int UP_W     = VA_W - HALF_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic [VA_W-1:0]   wrVaBegin,
  input  logic [VA_W-1:0]   wrVaEnd,
  input  logic [PA_W-1:0]   wrPaBase,
  input  logic [AT_W-1:0]   wrAccType,
  input  logic [PL_W-1:0]   wrPl1,
  input  logic [PL_W-1:0]   wrPl2,
  input  logic              wrDirty,
  input  logic              wrBreak,
  input  logic              wrTrap,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [1:0]        reqKind,
  input  logic [PL_W-1:0]   reqPriv,
  input  logic              physMode,
  input  logic              collectEn,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPa,
  output logic [2:0]        rspProt,
  output logic [2:0]        rspFault,
  output logic [HALF_W-1:0] offsetReg,
  output logic [UP_W-1:0]   spaceReg
);

  tlbStrobe_t strb;
  logic       faultAny;

  tlbchk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .physMode  (physMode),
    .collectEn (collectEn),
    .wrEn      (wrEn),
    .faultAny  (faultAny),
    .strb      (strb)
  );

  tlbchk_dp #(
    .N_ENT(N_ENT), .VA_W(VA_W), .PA_W(PA_W),
    .PAGE_BITS(PAGE_BITS), .PL_W(PL_W), .AT_W(AT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrIdx     (wrIdx),
    .wrValid   (wrValid),
    .wrVaBegin (wrVaBegin),
    .wrVaEnd   (wrVaEnd),
    .wrPaBase  (wrPaBase),
    .wrAccType (wrAccType),
    .wrPl1     (wrPl1),
    .wrPl2     (wrPl2),
    .wrDirty   (wrDirty),
    .wrBreak   (wrBreak),
    .wrTrap    (wrTrap),
    .reqVa     (reqVa),
    .reqKind   (reqKind),
    .reqPriv   (reqPriv),
    .rspPa     (rspPa),
    .rspProt   (rspProt),
    .rspFault  (rspFault),
    .faultAny  (faultAny),
    .offsetReg (offsetReg),
    .spaceReg  (spaceReg)
  );

  assign rspValid = strb.lookupEn;

endmodule

// File: tb/tlbchk_top_tb.sv
`timescale 1ns/1ps
module tlbchk_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrValid = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrVaBegin = '0, wrVaEnd = '0, wrPaBase = '0;
  logic [2:0]  wrAccType = '0;
  logic [1:0]  wrPl1 = '0, wrPl2 = '0;
  logic        wrDirty = 1'b0, wrBreak = 1'b0, wrTrap = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [1:0]  reqKind = '0, reqPriv = '0;
  logic        physMode = 1'b0, collectEn = 1'b0;
  logic        rspValid;
  logic [31:0] rspPa;
  logic [2:0]  rspProt, rspFault;
  logic [15:0] offsetReg, spaceReg;

  always #2.5 clk = ~clk;

  tlbchk_top u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrValid(wrValid),
    .wrVaBegin(wrVaBegin), .wrVaEnd(wrVaEnd), .wrPaBase(wrPaBase),
    .wrAccType(wrAccType), .wrPl1(wrPl1), .wrPl2(wrPl2), .wrDirty(wrDirty),
    .wrBreak(wrBreak), .wrTrap(wrTrap), .reqValid(reqValid), .reqVa(reqVa),
    .reqKind(reqKind), .reqPriv(reqPriv), .physMode(physMode),
    .collectEn(collectEn), .rspValid(rspValid), .rspPa(rspPa),
    .rspProt(rspProt), .rspFault(rspFault), .offsetReg(offsetReg),
    .spaceReg(spaceReg)
  );

  int checks = 0;
  int errors = 0;

  // bench-side mirror of the entry table
  logic        mV  [8];
  logic [31:0] mBeg[8], mEnd[8], mPa[8];
  logic [2:0]  mAt [8];
  logic [1:0]  mP1 [8], mP2[8];
  logic        mD  [8], mB[8], mT[8];
  logic [15:0] expOff = '0, expSp = '0;

  typedef struct {
    logic [31:0] pa;
    logic [2:0]  prot;
    logic [2:0]  fault;
  } res_t;

  function automatic res_t calcExp(logic [31:0] va, logic [1:0] kind,
                                   logic [1:0] priv, logic phys);
    res_t r;
    int   hit;
    logic rd, wr, ex;
    logic [2:0] g, nd;
    r.pa = 0; r.prot = 0; r.fault = 0;
    if (phys) begin
      r.pa = va; r.prot = 3'b111;
      return r;
    end
    hit = -1;
    for (int i = 7; i >= 0; i--)
      if (mV[i] && mBeg[i] <= va && va <= mEnd[i]) hit = i;
    if (hit < 0) begin
      r.fault = (kind == 2) ? 3'd1 : 3'd2;
      return r;
    end
    r.pa = mPa[hit] + {20'd0, va[11:0]};
    rd = priv <= mP1[hit];
    wr = priv <= mP2[hit];
    ex = (mP2[hit] <= priv) && (priv <= mP1[hit]);
    case (mAt[hit])
      3'd0: g = {1'b0, 1'b0, rd};
      3'd1: g = {1'b0, wr, rd};
      3'd2: g = {ex, 1'b0, rd};
      3'd3: g = {ex, wr, rd};
      default: g = {ex, 1'b0, 1'b0};
    endcase
    nd = (kind == 2) ? 3'b100 : ((kind == 1) ? 3'b010 : 3'b001);
    r.prot = g;
    if ((g & nd) == 0) begin
      r.fault = (kind == 2) ? 3'd3 : 3'd4;
      return r;
    end
    // applied lowest priority first so later ones override
    if (!mD[hit]) begin
      if (kind == 1) r.fault = 3'd5;
      r.prot[1] = 1'b0;
    end
    if (mB[hit]) begin
      if (kind == 1) r.fault = 3'd6;
      r.prot[1] = 1'b0;
    end
    if (mT[hit]) begin
      if (kind != 2) r.fault = 3'd7;
      r.prot = r.prot & 3'b100;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive an entry write (no wait) and update the mirror
  task automatic setWr(input int idx, input logic v, input logic [31:0] b,
                       input logic [31:0] e, input logic [31:0] pa,
                       input logic [2:0] at, input logic [1:0] p1,
                       input logic [1:0] p2, input logic d, input logic bk,
                       input logic t);
    wrEn = 1'b1; wrIdx = 3'(idx); wrValid = v; wrVaBegin = b; wrVaEnd = e;
    wrPaBase = pa; wrAccType = at; wrPl1 = p1; wrPl2 = p2;
    wrDirty = d; wrBreak = bk; wrTrap = t;
    mV[idx] = v; mBeg[idx] = b; mEnd[idx] = e; mPa[idx] = pa; mAt[idx] = at;
    mP1[idx] = p1; mP2[idx] = p2; mD[idx] = d; mB[idx] = bk; mT[idx] = t;
  endtask

  task automatic writeEnt(input int idx, input logic v, input logic [31:0] b,
                          input logic [31:0] e, input logic [31:0] pa,
                          input logic [2:0] at, input logic [1:0] p1,
                          input logic [1:0] p2, input logic d, input logic bk,
                          input logic t);
    setWr(idx, v, b, e, pa, at, p1, p2, d, bk, t);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic randWr(input int idx);
    logic [31:0] b;
    b = 32'h00A5_0000 + ($urandom % 32'h1_0000);
    setWr(idx, ($urandom % 5) != 0, b, b + ($urandom % 32'h3000),
          {($urandom % 32'h10_0000), 12'h000}, 3'($urandom), 2'($urandom),
          2'($urandom), 1'($urandom), (($urandom % 4) == 0),
          (($urandom % 4) == 0));
  endtask

  task automatic doLookup(input logic [31:0] va, input logic [1:0] kind,
                          input logic [1:0] priv, input logic phys,
                          input logic col, input string req);
    res_t e;
    e = calcExp(va, kind, priv, phys);
    reqVa = va; reqKind = kind; reqPriv = priv; physMode = phys;
    collectEn = col; reqValid = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; reqValid = 1'b0;
    chk(rspValid == 1'b1, {req, " R11 valid"}, 32'(rspValid), 32'd1);
    chk(rspPa == e.pa, {req, " pa"}, rspPa, e.pa);
    chk(rspProt == e.prot, {req, " prot"}, 32'(rspProt), 32'(e.prot));
    chk(rspFault == e.fault, {req, " fault"}, 32'(rspFault), 32'(e.fault));
    if (e.fault != 0 && col) begin
      expOff = va[15:0];
      expSp  = va[31:16];
    end
    @(negedge clk);
    chk(offsetReg == expOff, "R10 offset", 32'(offsetReg), 32'(expOff));
    chk(spaceReg == expSp, "R10 space", 32'(spaceReg), 32'(expSp));
    chk(rspValid == 1'b0 && rspFault == 0 && rspProt == 0 && rspPa == 0,
        "R11 idle zero", {rspPa[28:0], rspProt}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      mV[i] = 0; mBeg[i] = 0; mEnd[i] = 0; mPa[i] = 0; mAt[i] = 0;
      mP1[i] = 0; mP2[i] = 0; mD[i] = 0; mB[i] = 0; mT[i] = 0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk(rspValid == 1'b0, "R12 rspValid", 32'(rspValid), 32'd0);
    chk(offsetReg == 0 && spaceReg == 0, "R12 capture regs",
        {offsetReg, spaceReg}, 32'd0);
    doLookup(32'h0000_1234, 2'd2, 2'd0, 1'b0, 1'b1, "R12 R3 empty fetch miss");
    doLookup(32'h0000_1234, 2'd0, 2'd0, 1'b0, 1'b1, "R12 R3 empty load miss");

    // R2: bypass ignores entries
    doLookup(32'hDEAD_BEEF, 2'd1, 2'd3, 1'b1, 1'b1, "R2 bypass store");

    // R1 R4: overlapping ranges, lowest index wins, inclusive bounds
    writeEnt(0, 1, 32'h0001_1000, 32'h0001_2FFF, 32'h0040_0000, 3'd3, 2'd3, 2'd3, 1, 0, 0);
    writeEnt(1, 1, 32'h0001_2000, 32'h0001_3FFF, 32'h0080_0000, 3'd3, 2'd3, 2'd3, 1, 0, 0);
    doLookup(32'h0001_2ABC, 2'd0, 2'd0, 1'b0, 1'b1, "R1 R4 overlap first wins");
    doLookup(32'h0001_2FFF, 2'd1, 2'd0, 1'b0, 1'b1, "R1 end inclusive");
    doLookup(32'h0001_3000, 2'd2, 2'd0, 1'b0, 1'b1, "R1 second entry");
    doLookup(32'h0001_1000, 2'd3, 2'd0, 1'b0, 1'b1, "R1 R3 begin inclusive kind3");
    doLookup(32'h0001_0FFF, 2'd1, 2'd0, 1'b0, 1'b1, "R1 R3 below range");

    // R5 R6: privilege window and access types
    writeEnt(2, 1, 32'h0002_0000, 32'h0002_0FFF, 32'h0010_0000, 3'd3, 2'd1, 2'd0, 1, 0, 0);
    doLookup(32'h0002_0010, 2'd0, 2'd2, 1'b0, 1'b1, "R5 R7 read above pl1");
    doLookup(32'h0002_0020, 2'd2, 2'd0, 1'b0, 1'b1, "R5 exec in window");
    doLookup(32'h0002_0030, 2'd1, 2'd1, 1'b0, 1'b1, "R5 R7 write above pl2");
    writeEnt(2, 1, 32'h0002_0000, 32'h0002_0FFF, 32'h0010_0000, 3'd5, 2'd3, 2'd0, 1, 0, 0);
    doLookup(32'h0002_0040, 2'd0, 2'd0, 1'b0, 1'b1, "R6 R7 exec-only load");
    doLookup(32'h0002_0050, 2'd2, 2'd2, 1'b0, 1'b0, "R6 exec-only fetch");

    // R7 skips flags; R8 R9 flag priority
    writeEnt(3, 1, 32'h0003_0000, 32'h0003_0FFF, 32'h0020_0000, 3'd0, 2'd3, 2'd3, 0, 1, 1);
    doLookup(32'h0003_0100, 2'd1, 2'd0, 1'b0, 1'b1, "R7 prot beats trap");
    doLookup(32'h0003_0104, 2'd2, 2'd0, 1'b0, 1'b1, "R7 fetch prot");
    writeEnt(3, 1, 32'h0003_0000, 32'h0003_0FFF, 32'h0020_0000, 3'd3, 2'd3, 2'd3, 0, 1, 1);
    doLookup(32'h0003_0200, 2'd1, 2'd0, 1'b0, 1'b1, "R9 trap over break");
    doLookup(32'h0003_0204, 2'd2, 2'd0, 1'b0, 1'b1, "R8 fetch passes trap");
    writeEnt(3, 1, 32'h0003_0000, 32'h0003_0FFF, 32'h0020_0000, 3'd3, 2'd3, 2'd3, 0, 1, 0);
    doLookup(32'h0003_0300, 2'd1, 2'd0, 1'b0, 1'b1, "R9 break over dirty");
    doLookup(32'h0003_0304, 2'd0, 2'd0, 1'b0, 1'b1, "R8 load with break");
    writeEnt(3, 1, 32'h0003_0000, 32'h0003_0FFF, 32'h0020_0000, 3'd1, 2'd3, 2'd3, 0, 0, 0);
    doLookup(32'h0003_0400, 2'd1, 2'd0, 1'b0, 1'b1, "R8 dirty store");

    // R10: no capture with collection off
    doLookup(32'h0BAD_0404, 2'd1, 2'd0, 1'b0, 1'b0, "R10 collect off miss");

    // R11: write and lookup on the same edge
    setWr(5, 1, 32'h0005_0000, 32'h0005_0FFF, 32'h0030_0000, 3'd1, 2'd3, 2'd3, 1, 0, 0);
    doLookup(32'h0005_0123, 2'd1, 2'd0, 1'b0, 1'b1, "R11 same-edge write");

    // mixed random run
    for (int n = 0; n < 600; n++) begin
      logic [31:0] va;
      if (($urandom % 4) == 0) writeEnt($urandom % 8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      if (($urandom % 3) == 0) begin
        randWr($urandom % 8);
        @(negedge clk);
        wrEn = 1'b0;
      end
      if (($urandom % 8) == 0) randWr($urandom % 8);
      va = 32'h00A5_0000 + ($urandom % 32'h1_4000);
      doLookup(va, 2'($urandom), 2'($urandom), (($urandom % 10) == 0),
               (($urandom % 10) < 7), "R1 R5 R6 R8 R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule